// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical page number by walking a two-level page table held in memory. Pages are 4 KB. The virtual address is split into three parts. The top ten bits select a 4-byte entry in a root table, and the root table's base address is given on an input. If that entry is present, it points to a second table page. The next ten bits select the leaf entry in that page. The low twelve bits are the page offset, and the walker does not use them.

A requester hands over one virtual address together with an access type (read, write or instruction fetch). The walker then issues up to two dependent reads on a simple memory port that allows one outstanding read at a time. It returns either the leaf's physical page number and rights, or a fault. A fault reports what went wrong, which level it happened at, and the faulting virtual address. The walker keeps no translations. It does not update used or dirty bits, and it leaves fault handling to software.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: The first memory read of a walk goes to the root base sampled when the request was accepted, plus four times `vaddr[31:22]`. Changes on `root_base` after acceptance have no effect on the walk.
- R3: The second read goes to the first-level entry's page number shifted left by 12, plus four times `vaddr[21:12]`.
- R4: The entry format is as follows:
  - bit 0 is present;
  - bits [2:1] are rights (00 read-only, 01 read/write, 10 read/execute, 11 no access);
  - bits [31:12] are the page number.
  
  A permitted walk with a present leaf ends with `rsp_fault`=0 and `rsp_fault_kind`=00. It returns the leaf's page number and rights. The rights bits of a first-level entry are ignored.
- R5: A first-level entry with bit 0 clear ends the walk with `rsp_fault`=1, kind 01 (not present) and level 0. No second read is issued. `rsp_fault_vaddr` equals the requested address.
- R6: A leaf with bit 0 clear ends the walk with kind 01 at level 1.
- R7: The access codes are 00 read, 01 write, 10 fetch and 11 reserved. Read is allowed by rights 00, 01 and 10; write only by 01; fetch only by 10; code 11 by nothing. A present leaf that does not permit the access ends the walk with kind 10 (protection) at level 1.
- R8: At most one memory read is outstanding. `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready` is seen.
- R9: A request is accepted only when `req_ready` is 1. `req_valid` while busy causes no extra memory read and does not change the response.
- R10: A response holds with all its fields stable until `rsp_ready`. The walker is ready again one cycle after the handshake.
- R11: The timing assumes a memory with `mem_req_ready` held at 1 that returns data one cycle after a read is accepted. Under that memory, `rsp_valid` rises on the fourth rising edge after the accepting edge for a full walk, and on the second for a first-level fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_access | input | 2 | Access type: 00 read, 01 write, 10 fetch |
| root_base | input | 32 | Physical byte address of the root table |
| mem_req_valid | output | 1 | Entry read requested |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Walk result available |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_ppn | output | 20 | Physical page number of the leaf |
| rsp_rights | output | 2 | Rights field of the leaf |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_fault_kind | output | 2 | 00 none, 01 not present, 10 protection |
| rsp_fault_level | output | 1 | 0 first level, 1 second level |
| rsp_fault_vaddr | output | 32 | Faulting virtual address (zero on success) |

## Verification
The walker's results depend on when memory answers, so the bench counts falling edges from the accepting rising edge until the result appears. With a memory that never stalls and answers one cycle after each read, a full walk must show `rsp_valid` at the fifth falling edge and a first-level fault at the third. The bench compares that count exactly and samples every result field at that same falling edge. It records the address of every read at the edge where the read is accepted, and checks the addresses and the number of reads once the walk ends. A second pass alternates `mem_req_ready` and holds back `rsp_ready`. That pass checks results and held values but not timing, since latency is no longer fixed.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_L1_REQ  = 3'd1,
        S_L1_WAIT = 3'd2,
        S_L2_REQ  = 3'd3,
        S_L2_WAIT = 3'd4,
        S_DONE    = 3'd5,
        S_FAULT   = 3'd6
    } walk_state_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } access_e;

    typedef enum logic [1:0] {
        RT_RO   = 2'd0,
        RT_RW   = 2'd1,
        RT_RX   = 2'd2,
        RT_NONE = 2'd3
    } rights_e;

    typedef enum logic [1:0] {
        FK_NONE   = 2'd0,
        FK_ABSENT = 2'd1,
        FK_PROT   = 2'd2,
        FK_RSVD   = 2'd3
    } fault_e;

endpackage

// File: rtl/ptw_index_addr.sv
module ptw_index_addr #(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int OFF_W     = 12,
    parameter int IDX_W     = 10,
    parameter int PTE_BYTES = 4
) (
    input  logic [PA_W-1:0]       root_base,
    input  logic [VA_W-1:0]       vaddr,
    input  logic [PA_W-OFF_W-1:0] table_ppn,
    output logic [PA_W-1:0]       l1_addr,
    output logic [PA_W-1:0]       l2_addr
);
    localparam int PPN_W = PA_W - OFF_W;
    localparam int SH    = $clog2(PTE_BYTES);

    logic [IDX_W-1:0] idx_top;
    logic [IDX_W-1:0] idx_mid;
    logic [PA_W-1:0]  table_base;

    // Top slice picks the root entry, the slice above the offset picks the leaf.
    assign idx_top    = vaddr[VA_W-1 -: IDX_W];
    assign idx_mid    = vaddr[OFF_W +: IDX_W];
    assign table_base = {table_ppn, {OFF_W{1'b0}}};

    assign l1_addr = root_base  + (PA_W'(idx_top) << SH);
    assign l2_addr = table_base + (PA_W'(idx_mid) << SH);

    logic unused_ok;
    assign unused_ok = &{1'b0, vaddr[OFF_W-1:0], PPN_W[0]};

endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
    parameter int PA_W      = 32,
    parameter int OFF_W     = 12,
    parameter int PTE_BYTES = 4
) (
    input  logic [8*PTE_BYTES-1:0] pte,
    input  logic [1:0]             access,
    output logic                   present,
    output logic [1:0]             rights,
    output logic [PA_W-OFF_W-1:0]  ppn,
    output logic                   permit
);
    import ptw_pkg::*;

    localparam int PTE_W = 8 * PTE_BYTES;
    localparam int PPN_W = PA_W - OFF_W;

    assign present = pte[0];
    assign rights  = pte[2:1];
    assign ppn     = pte[PTE_W-1 -: PPN_W];

    always_comb begin
        permit = 1'b0;
        case (access)
            ACC_READ:  permit = (rights != RT_NONE);
            ACC_WRITE: permit = (rights == RT_RW);
            ACC_FETCH: permit = (rights == RT_RX);
            default:   permit = 1'b0;
        endcase
    end

    logic unused_ok;
    assign unused_ok = &{1'b0, pte[PTE_W-PPN_W-1:3]};

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int OFF_W     = 12,
    parameter int IDX_W     = 10,
    parameter int PTE_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [VA_W-1:0]        req_vaddr,
    input  logic [1:0]             req_access,
    input  logic [PA_W-1:0]        root_base,
    output logic                   mem_req_valid,
    input  logic                   mem_req_ready,
    output logic [PA_W-1:0]        mem_req_addr,
    input  logic                   mem_rsp_valid,
    input  logic [8*PTE_BYTES-1:0] mem_rsp_data,
    output logic                   rsp_valid,
    input  logic                   rsp_ready,
    output logic [PA_W-OFF_W-1:0]  rsp_ppn,
    output logic [1:0]             rsp_rights,
    output logic                   rsp_fault,
    output logic [1:0]             rsp_fault_kind,
    output logic                   rsp_fault_level,
    output logic [VA_W-1:0]        rsp_fault_vaddr
);
    import ptw_pkg::*;

    localparam int PPN_W = PA_W - OFF_W;

    typedef struct packed {
        walk_state_e      st;
        logic [VA_W-1:0]  vaddr;
        logic [1:0]       acc;
        logic [PA_W-1:0]  root;
        logic [PPN_W-1:0] tbl_ppn;
        logic [PPN_W-1:0] ppn;
        logic [1:0]       rights;
        logic [1:0]       fkind;
        logic             flevel;
    } walk_regs_t;

    walk_regs_t walk_d, walk_q;

    logic [PA_W-1:0]  l1_addr;
    logic [PA_W-1:0]  l2_addr;
    logic             ent_present;
    logic [1:0]       ent_rights;
    logic [PPN_W-1:0] ent_ppn;
    logic             ent_permit;

    ptw_index_addr #(
        .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .PTE_BYTES(PTE_BYTES)
    ) u_addr (
        .root_base (walk_q.root),
        .vaddr     (walk_q.vaddr),
        .table_ppn (walk_q.tbl_ppn),
        .l1_addr   (l1_addr),
        .l2_addr   (l2_addr)
    );

    ptw_pte_decode #(
        .PA_W(PA_W), .OFF_W(OFF_W), .PTE_BYTES(PTE_BYTES)
    ) u_dec (
        .pte     (mem_rsp_data),
        .access  (walk_q.acc),
        .present (ent_present),
        .rights  (ent_rights),
        .ppn     (ent_ppn),
        .permit  (ent_permit)
    );

    always_comb begin
        walk_d = walk_q;
        case (walk_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    walk_d.vaddr   = req_vaddr;
                    walk_d.acc     = req_access;
                    walk_d.root    = root_base;
                    walk_d.tbl_ppn = '0;
                    walk_d.ppn     = '0;
                    walk_d.rights  = '0;
                    walk_d.fkind   = FK_NONE;
                    walk_d.flevel  = 1'b0;
                    walk_d.st      = S_L1_REQ;
                end
            end
            S_L1_REQ: begin
                if (mem_req_ready) walk_d.st = S_L1_WAIT;
            end
            S_L1_WAIT: begin
                if (mem_rsp_valid) begin
                    if (ent_present) begin
                        walk_d.tbl_ppn = ent_ppn;
                        walk_d.st      = S_L2_REQ;
                    end else begin
                        walk_d.fkind  = FK_ABSENT;
                        walk_d.flevel = 1'b0;
                        walk_d.st     = S_FAULT;
                    end
                end
            end
            S_L2_REQ: begin
                if (mem_req_ready) walk_d.st = S_L2_WAIT;
            end
            S_L2_WAIT: begin
                if (mem_rsp_valid) begin
                    walk_d.flevel = 1'b1;
                    if (!ent_present) begin
                        walk_d.fkind = FK_ABSENT;
                        walk_d.st    = S_FAULT;
                    end else if (!ent_permit) begin
                        walk_d.fkind = FK_PROT;
                        walk_d.st    = S_FAULT;
                    end else begin
                        walk_d.ppn    = ent_ppn;
                        walk_d.rights = ent_rights;
                        walk_d.st     = S_DONE;
                    end
                end
            end
            S_DONE, S_FAULT: begin
                if (rsp_ready) walk_d.st = S_IDLE;
            end
            default: walk_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) walk_q <= '0;
        else        walk_q <= walk_d;
    end

    assign req_ready       = (walk_q.st == S_IDLE);
    assign mem_req_valid   = (walk_q.st == S_L1_REQ) || (walk_q.st == S_L2_REQ);
    assign mem_req_addr    = (walk_q.st == S_L1_REQ) ? l1_addr : l2_addr;
    assign rsp_valid       = (walk_q.st == S_DONE) || (walk_q.st == S_FAULT);
    assign rsp_fault       = (walk_q.st == S_FAULT);
    assign rsp_ppn         = walk_q.ppn;
    assign rsp_rights      = walk_q.rights;
    assign rsp_fault_kind  = walk_q.fkind;
    assign rsp_fault_level = walk_q.flevel;
    assign rsp_fault_vaddr = (walk_q.st == S_FAULT) ? walk_q.vaddr : '0;

    // R8: a read waiting for acceptance keeps its address.
    a_r8_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R10: an unaccepted result keeps every field.
    a_r10_hold_response: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_ppn) && $stable(rsp_rights)
                                       && $stable(rsp_fault) && $stable(rsp_fault_kind)));

    // R9: taking a request makes the walker busy on the next cycle.
    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R5: a fault always carries a nonzero kind.
    a_r5_fault_has_kind: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_valid && rsp_fault_kind != FK_NONE));

    // R4: a successful result carries no fault kind.
    a_r4_success_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_fault_kind == FK_NONE));

    // R8: never a read and a result at the same time.
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_valid && rsp_valid));

endmodule

// File: tb/tb_ptw_walker.sv
`timescale 1ns/1ps
module tb_ptw_walker;

    localparam logic [31:0] ROOT   = 32'h0010_0000;
    localparam logic [19:0] L2BASE = 20'h00400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_access = '0;
    logic [31:0] root_base = ROOT;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [19:0] rsp_ppn;
    logic [1:0]  rsp_rights;
    logic        rsp_fault;
    logic [1:0]  rsp_fault_kind;
    logic        rsp_fault_level;
    logic [31:0] rsp_fault_vaddr;

    int          n_chk = 0;
    int          n_fail = 0;
    logic        stall_mode = 1'b0;
    int          rd_cnt = 0;
    logic [31:0] rd_log [4];

    always #2 clk = ~clk;

    ptw_walker dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_access(req_access), .root_base(root_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_ppn(rsp_ppn), .rsp_rights(rsp_rights), .rsp_fault(rsp_fault),
        .rsp_fault_kind(rsp_fault_kind), .rsp_fault_level(rsp_fault_level),
        .rsp_fault_vaddr(rsp_fault_vaddr)
    );

    // Table contents as functions of the two indices.
    function automatic logic l1_present(input int i1);
        return (i1 % 5) != 3;
    endfunction
    function automatic logic l2_present(input int i1, input int i2);
        return ((i1 + i2) % 7) != 0;
    endfunction
    function automatic logic [1:0] l2_rights(input int i1, input int i2);
        return 2'((i1 * 3 + i2) % 4);
    endfunction
    function automatic logic [19:0] l2_ppn(input int i1, input int i2);
        return {10'(i1), 10'(i2)} ^ 20'h5A5A5;
    endfunction

    function automatic logic [31:0] mem_fn(input logic [31:0] a);
        int i1, i2;
        if (a[31:12] == ROOT[31:12]) begin
            i1 = int'(a[11:2]);
            // rights bits deliberately set to junk at the first level
            return {L2BASE + 20'(i1), 9'd0, 2'(i1), l1_present(i1)};
        end
        i1 = int'(10'(a[31:12] - L2BASE));
        i2 = int'(a[11:2]);
        return {l2_ppn(i1, i2), 9'd0, l2_rights(i1, i2), l2_present(i1, i2)};
    endfunction

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            rd_log[rd_cnt % 4] <= mem_req_addr;
            rd_cnt             <= rd_cnt + 1;
            mem_rsp_valid      <= 1'b1;
            mem_rsp_data       <= mem_fn(mem_req_addr);
        end
        mem_req_ready <= stall_mode ? ~mem_req_ready : 1'b1;
    end

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic walk(input int i1, input int i2, input int acc, input logic stall);
        logic [31:0] va;
        logic        perm;
        logic [1:0]  ert;
        int          lat;
        int          start_cnt;
        logic [19:0] hold_ppn;
        logic [1:0]  hold_kind;
        va  = {10'(i1), 10'(i2), 12'(i1 * 7 + i2)};
        ert = l2_rights(i1, i2);
        case (acc)
            0: perm = (ert != 2'd3);
            1: perm = (ert == 2'd1);
            2: perm = (ert == 2'd2);
            default: perm = 1'b0;
        endcase
        @(negedge clk);
        chk("R9", "ready before request", 32'(req_ready), 32'd1);
        start_cnt  = rd_cnt;
        req_vaddr  = va;
        req_access = 2'(acc);
        root_base  = ROOT;
        req_valid  = 1'b1;
        if (stall) rsp_ready = 1'b0;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        if (stall) begin
            // R2/R9: root change and a stray request while busy must not matter
            root_base  = 32'hDEAD_0000;
            req_vaddr  = ~va;
            req_access = 2'd3;
            req_valid  = 1'b1;
        end
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!rsp_valid && lat < 60);
        if (!stall)
            chk("R11", "latency", 32'(lat), l1_present(i1) ? 32'd5 : 32'd3);
        if (!l1_present(i1)) begin
            chk("R5", "fault", 32'(rsp_fault), 32'd1);
            chk("R5", "kind", 32'(rsp_fault_kind), 32'd1);
            chk("R5", "level", 32'(rsp_fault_level), 32'd0);
            chk("R5", "vaddr echo", rsp_fault_vaddr, va);
            chk("R5", "read count", 32'(rd_cnt - start_cnt), 32'd1);
        end else if (!l2_present(i1, i2)) begin
            chk("R6", "fault", 32'(rsp_fault), 32'd1);
            chk("R6", "kind", 32'(rsp_fault_kind), 32'd1);
            chk("R6", "level", 32'(rsp_fault_level), 32'd1);
            chk("R6", "vaddr echo", rsp_fault_vaddr, va);
        end else if (!perm) begin
            chk("R7", "fault", 32'(rsp_fault), 32'd1);
            chk("R7", "kind", 32'(rsp_fault_kind), 32'd2);
            chk("R7", "level", 32'(rsp_fault_level), 32'd1);
            chk("R7", "vaddr echo", rsp_fault_vaddr, va);
        end else begin
            chk("R4", "fault", 32'(rsp_fault), 32'd0);
            chk("R4", "kind", 32'(rsp_fault_kind), 32'd0);
            chk("R4", "ppn", 32'(rsp_ppn), 32'(l2_ppn(i1, i2)));
            chk("R4", "rights", 32'(rsp_rights), 32'(ert));
        end
        chk("R2", "first read address", rd_log[start_cnt % 4], ROOT + 32'(i1 * 4));
        if (l1_present(i1)) begin
            chk("R3", "second read address", rd_log[(start_cnt + 1) % 4],
                {L2BASE + 20'(i1), 12'd0} + 32'(i2 * 4));
            chk("R8", "read count", 32'(rd_cnt - start_cnt), 32'd2);
        end
        if (stall) begin
            hold_ppn  = rsp_ppn;
            hold_kind = rsp_fault_kind;
            for (int k = 0; k < 3; k++) @(negedge clk);
            chk("R10", "valid held", 32'(rsp_valid), 32'd1);
            chk("R10", "ppn held", 32'(rsp_ppn), 32'(hold_ppn));
            chk("R10", "kind held", 32'(rsp_fault_kind), 32'(hold_kind));
            chk("R9", "busy while holding", 32'(req_ready), 32'd0);
            chk("R9", "no stray reads", 32'(rd_cnt - start_cnt), l1_present(i1) ? 32'd2 : 32'd1);
            req_valid = 1'b0;
            rsp_ready = 1'b1;
        end
        @(negedge clk);
        chk("R10", "ready after handshake", 32'(req_ready), 32'd1);
        chk("R10", "result cleared", 32'(rsp_valid), 32'd0);
    endtask

    initial begin
        #(4ns * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int i1s[8] = '{0, 1, 3, 5, 8, 512, 1022, 1023};
        int i2s[5] = '{0, 1, 6, 500, 1023};
        int s1[3]  = '{1, 5, 1023};
        int s2[2]  = '{6, 1023};
        repeat (3) @(negedge clk);
        chk("R1", "req_ready in reset", 32'(req_ready), 32'd1);
        chk("R1", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
        chk("R1", "mem_req_valid in reset", 32'(mem_req_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "req_ready after reset", 32'(req_ready), 32'd1);
        foreach (i1s[a]) foreach (i2s[b])
            for (int acc = 0; acc < 4; acc++) walk(i1s[a], i2s[b], acc, 1'b0);
        stall_mode = 1'b1;
        foreach (s1[a]) foreach (s2[b])
            for (int acc = 0; acc < 4; acc++) walk(s1[a], s2[b], acc, 1'b1);
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule